// File: doc/BRIEF.md
# Chip-Select Address Window Decoder

This block maps a bus address onto one of several external memory regions. Each region has an enable, a base address, a 4-bit size code and a 2-bit data-width code. The size code sets the region to a power of two between 64 KB and 2 GB. The larger the region, the fewer upper address bits are compared against its base. The decoder is combinational from the address to its outputs. It drives a one-hot chip-select vector and reports the bus width of the selected region. If the winning region has been programmed with the reserved width value, it raises an error flag instead of a chip select.

The region settings are held in registers loaded through a one-cycle write port. A write names a region index and supplies all of that region's fields together. Where regions overlap, the enabled region with the lowest index wins.

Top module: `cs_window_decoder`

## Requirements
- R1: After reset every region is disabled, so for any address `cs_sel` is zero, `bus_width` is 00 and `width_err` is 0.
- R2: Size code 0 makes a 64 KB region: the address matches when bits 31..16 equal the same bits of the base.
- R3: Size code k (0..15) compares address bits 31 down to 16+k, so each step doubles the region size.
- R4: Size code 15 makes a 2048 MB region that compares only address bit 31.
- R5: Base bits below the compared range have no effect on matching.
- R6: A disabled region never asserts its chip select, whatever its base.
- R7: When several enabled regions match, only the lowest-numbered one is selected. `cs_sel` has bit i set for region i and is never more than one-hot.
- R8: When a region is selected, `bus_width` repeats its width code: 00 for 8-bit, 01 for 16-bit, 10 for 32-bit.
- R9: When the winning region's width code is 11 (reserved), `cs_sel` is zero, `bus_width` is 00 and `width_err` is 1. A higher-numbered matching region does not take over.
- R10: When no enabled region matches, `cs_sel` is zero, `bus_width` is 00 and `width_err` is 0.
- R11: With `cfg_we` high at a rising clock edge, region `cfg_idx` takes all the `cfg_*` fields from that edge onward. With `cfg_we` low, the `cfg_*` inputs change nothing, and a write leaves all other regions unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the region registers |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write strobe for one region's settings |
| cfg_idx | input | 3 | Region index to write |
| cfg_en | input | 1 | Enable value to write |
| cfg_base | input | 32 | Base address to write |
| cfg_size | input | 4 | Size code to write (64 KB shifted left by code) |
| cfg_width | input | 2 | Width code to write (00 byte, 01 half, 10 word, 11 reserved) |
| bus_addr | input | 32 | Address to decode |
| cs_sel | output | 8 | One-hot chip-select vector |
| bus_width | output | 2 | Width code of the selected region, 00 when none |
| width_err | output | 1 | Winning region has the reserved width code |

## Verification
A bad stored base or size code shows up as a chip select that appears or disappears at the region edge. It is visible on the first address probe after the faulty write, because the decode path has no register. Several tests put addresses one byte inside and one byte outside each region. A broken priority or enable term shows up as a different one-hot bit when regions overlap. A broken reserved-width path shows up as a chip select next to a raised error flag. The scoreboard compares all three outputs on every probe, so any single-field fault is caught at once.

// File: rtl/cs_window_pkg.sv
package cs_window_pkg;
   typedef enum logic [1:0] {
      BW_BYTE = 2'b00,
      BW_HALF = 2'b01,
      BW_WORD = 2'b10,
      BW_RSVD = 2'b11
   } bus_width_e;

   localparam int unsigned CSW_MIN_LOG2 = 16;
endpackage

// File: rtl/cs_region_regs.sv
module cs_region_regs #(
   parameter int unsigned NUM_REGIONS = 8,
   parameter int unsigned ADDR_W      = 32,
   parameter int unsigned SIZE_W      = 4,
   parameter int unsigned WIDTH_W     = 2,
   localparam int unsigned IDX_W      = $clog2(NUM_REGIONS)
) (
   input  logic                                  clk,
   input  logic                                  rst_n,
   input  logic                                  wr_en,
   input  logic [IDX_W-1:0]                      wr_idx,
   input  logic                                  wr_enable,
   input  logic [ADDR_W-1:0]                     wr_base,
   input  logic [SIZE_W-1:0]                     wr_size,
   input  logic [WIDTH_W-1:0]                    wr_width,
   output logic [NUM_REGIONS-1:0]                en_q,
   output logic [NUM_REGIONS-1:0][ADDR_W-1:0]    base_q,
   output logic [NUM_REGIONS-1:0][SIZE_W-1:0]    size_q,
   output logic [NUM_REGIONS-1:0][WIDTH_W-1:0]   width_q
);
   for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            en_q[g]    <= 1'b0;
            base_q[g]  <= '0;
            size_q[g]  <= '0;
            width_q[g] <= '0;
         end else if (wr_en && (wr_idx == IDX_W'(g))) begin
            en_q[g]    <= wr_enable;
            base_q[g]  <= wr_base;
            size_q[g]  <= wr_size;
            width_q[g] <= wr_width;
         end
      end
   end
endmodule

// File: rtl/cs_region_match.sv
module cs_region_match #(
   parameter int unsigned ADDR_W   = 32,
   parameter int unsigned SIZE_W   = 4,
   parameter int unsigned MIN_LOG2 = 16,
   localparam int unsigned SH_W    = $clog2(ADDR_W) + 1
) (
   input  logic              enable,
   input  logic [ADDR_W-1:0] base,
   input  logic [SIZE_W-1:0] size_code,
   input  logic [ADDR_W-1:0] addr,
   output logic              hit
);
   logic [SH_W-1:0]   shamt;
   logic [ADDR_W-1:0] diff;

   always_comb begin
      shamt = SH_W'(MIN_LOG2) + SH_W'(size_code);
      diff  = addr ^ base;
      hit   = enable && ((diff >> shamt) == '0);
   end
endmodule

// File: rtl/cs_priority_pick.sv
module cs_priority_pick #(
   parameter int unsigned NUM_REGIONS = 8,
   localparam int unsigned IDX_W      = $clog2(NUM_REGIONS)
) (
   input  logic [NUM_REGIONS-1:0] hit_vec,
   output logic                   any_hit,
   output logic [IDX_W-1:0]       win_idx,
   output logic [NUM_REGIONS-1:0] win_onehot
);
   always_comb begin
      win_idx = '0;
      for (int i = NUM_REGIONS - 1; i >= 0; i--) begin
         if (hit_vec[i]) win_idx = IDX_W'(i);
      end
      any_hit    = |hit_vec;
      win_onehot = any_hit ? (NUM_REGIONS'(1) << win_idx) : '0;
   end
endmodule

// File: rtl/cs_window_decoder.sv
module cs_window_decoder
   import cs_window_pkg::*;
#(
   parameter int unsigned NUM_REGIONS = 8,
   parameter int unsigned ADDR_W      = 32,
   parameter int unsigned SIZE_W      = 4,
   parameter int unsigned WIDTH_W     = 2,
   parameter int unsigned MIN_LOG2    = CSW_MIN_LOG2
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             cfg_we,
   input  logic [$clog2(NUM_REGIONS)-1:0]   cfg_idx,
   input  logic                             cfg_en,
   input  logic [ADDR_W-1:0]                cfg_base,
   input  logic [SIZE_W-1:0]                cfg_size,
   input  logic [WIDTH_W-1:0]               cfg_width,
   input  logic [ADDR_W-1:0]                bus_addr,
   output logic [NUM_REGIONS-1:0]           cs_sel,
   output logic [WIDTH_W-1:0]               bus_width,
   output logic                             width_err
);
   localparam int unsigned IDX_W    = $clog2(NUM_REGIONS);
   localparam int unsigned TOP_LOW  = MIN_LOG2 + (1 << SIZE_W) - 1;

   if (NUM_REGIONS < 2) begin : g_bad_regions
      $error("cs_window_decoder: NUM_REGIONS must be at least 2");
   end
   if (TOP_LOW > ADDR_W - 1) begin : g_bad_span
      $error("cs_window_decoder: largest size code leaves no compared address bit");
   end
   if (WIDTH_W != $bits(bus_width_e)) begin : g_bad_width
      $error("cs_window_decoder: WIDTH_W must match the width code type");
   end

   logic [NUM_REGIONS-1:0]               en_q;
   logic [NUM_REGIONS-1:0][ADDR_W-1:0]   base_q;
   logic [NUM_REGIONS-1:0][SIZE_W-1:0]   size_q;
   logic [NUM_REGIONS-1:0][WIDTH_W-1:0]  width_q;
   logic [NUM_REGIONS-1:0]               hit_vec;
   logic                                 any_hit;
   logic [IDX_W-1:0]                     win_idx;
   logic [NUM_REGIONS-1:0]               win_onehot;
   bus_width_e                           win_width;
   logic                                 rsvd;

   cs_region_regs #(
      .NUM_REGIONS(NUM_REGIONS), .ADDR_W(ADDR_W),
      .SIZE_W(SIZE_W), .WIDTH_W(WIDTH_W)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .wr_en(cfg_we), .wr_idx(cfg_idx), .wr_enable(cfg_en),
      .wr_base(cfg_base), .wr_size(cfg_size), .wr_width(cfg_width),
      .en_q(en_q), .base_q(base_q), .size_q(size_q), .width_q(width_q)
   );

   for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_match
      cs_region_match #(
         .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .MIN_LOG2(MIN_LOG2)
      ) u_match (
         .enable(en_q[g]), .base(base_q[g]), .size_code(size_q[g]),
         .addr(bus_addr), .hit(hit_vec[g])
      );
   end

   cs_priority_pick #(.NUM_REGIONS(NUM_REGIONS)) u_pick (
      .hit_vec(hit_vec), .any_hit(any_hit),
      .win_idx(win_idx), .win_onehot(win_onehot)
   );

   always_comb begin
      win_width = bus_width_e'(width_q[win_idx]);
      rsvd      = any_hit && (win_width == BW_RSVD);
      cs_sel    = rsvd ? '0 : win_onehot;
      bus_width = (any_hit && !rsvd) ? WIDTH_W'(win_width) : '0;
      width_err = rsvd;
   end
endmodule

// File: rtl/cs_window_decoder_chk.sv
module cs_window_decoder_chk #(
   parameter int unsigned NUM_REGIONS = 8,
   parameter int unsigned WIDTH_W     = 2
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   cfg_we,
   input logic [NUM_REGIONS-1:0] cs_sel,
   input logic [WIDTH_W-1:0]     bus_width,
   input logic                   width_err,
   input logic [NUM_REGIONS-1:0] region_en
);
   // R7
   one_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(cs_sel));

   // R9
   err_blocks_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      width_err |-> (cs_sel == '0 && bus_width == '0));

   // R10
   idle_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_sel == '0) |-> (bus_width == '0));

   // R8
   sel_width_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_sel != '0) |-> (bus_width != {WIDTH_W{1'b1}}));

   // R6
   disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_sel & ~region_en) == '0);

   // R11
   no_write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_we |=> $stable(region_en));
endmodule

bind cs_window_decoder cs_window_decoder_chk #(
   .NUM_REGIONS(NUM_REGIONS), .WIDTH_W(WIDTH_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cs_sel(cs_sel),
   .bus_width(bus_width), .width_err(width_err), .region_en(en_q)
);

// File: tb/cs_window_decoder_bench.sv
module cs_window_decoder_bench;
   localparam int unsigned CLK_PERIOD = 10;
   localparam int unsigned NR = 8;

   typedef struct {
      logic [7:0] cs;
      logic [1:0] w;
      logic       e;
      string      tag;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [2:0]  cfg_idx = '0;
   logic        cfg_en = 1'b0;
   logic [31:0] cfg_base = '0;
   logic [3:0]  cfg_size = '0;
   logic [1:0]  cfg_width = '0;
   logic [31:0] bus_addr = '0;
   logic [7:0]  cs_sel;
   logic [1:0]  bus_width;
   logic        width_err;

   int checks = 0;
   int errors = 0;
   bit finished = 0;
   exp_t q[$];

   logic        m_en[NR];
   logic [31:0] m_base[NR];
   logic [3:0]  m_size[NR];
   logic [1:0]  m_width[NR];

   always #(CLK_PERIOD / 2) clk = ~clk;

   cs_window_decoder u_cs_window_decoder (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
      .cfg_en(cfg_en), .cfg_base(cfg_base), .cfg_size(cfg_size),
      .cfg_width(cfg_width), .bus_addr(bus_addr),
      .cs_sel(cs_sel), .bus_width(bus_width), .width_err(width_err)
   );

   function automatic exp_t model(input logic [31:0] a, input string tag);
      exp_t r;
      r.cs = '0; r.w = '0; r.e = 1'b0; r.tag = tag;
      for (int i = 0; i < NR; i++) begin
         if (m_en[i] && (((a ^ m_base[i]) >> (16 + m_size[i])) == 0)) begin
            if (m_width[i] == 2'b11) r.e = 1'b1;
            else begin
               r.cs = 8'(1 << i);
               r.w  = m_width[i];
            end
            return r;
         end
      end
      return r;
   endfunction

   task automatic cfg_write(input int idx, input logic en, input logic [31:0] base,
                            input logic [3:0] size, input logic [1:0] width);
      @(negedge clk);
      cfg_we = 1'b1; cfg_idx = 3'(idx); cfg_en = en;
      cfg_base = base; cfg_size = size; cfg_width = width;
      @(negedge clk);
      cfg_we = 1'b0;
      m_en[idx] = en; m_base[idx] = base; m_size[idx] = size; m_width[idx] = width;
   endtask

   task automatic probe(input logic [31:0] a, input string tag);
      @(negedge clk);
      bus_addr = a;
      q.push_back(model(a, tag));
   endtask

   task automatic probe_exp(input logic [31:0] a, input logic [7:0] cs,
                            input logic [1:0] w, input logic e, input string tag);
      exp_t r;
      r.cs = cs; r.w = w; r.e = e; r.tag = tag;
      @(negedge clk);
      bus_addr = a;
      q.push_back(r);
   endtask

   // monitor
   initial begin
      forever begin
         exp_t x;
         wait (q.size() > 0);
         #1;
         x = q.pop_front();
         checks++;
         if (cs_sel !== x.cs || bus_width !== x.w || width_err !== x.e) begin
            errors++;
            $display("FAIL %s: cs=%b w=%b err=%b expected cs=%b w=%b err=%b",
                     x.tag, cs_sel, bus_width, width_err, x.cs, x.w, x.e);
         end
      end
   end

   // watchdog
   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         checks++; errors++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < NR; i++) begin
         m_en[i] = 1'b0; m_base[i] = '0; m_size[i] = '0; m_width[i] = '0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state, any address
      probe_exp(32'h0000_0000, 8'h00, 2'b00, 1'b0, "R1 reset addr0");
      probe_exp(32'hFFFF_FFFF, 8'h00, 2'b00, 1'b0, "R1 reset addr max");

      // R2: 64 KB region, width half
      cfg_write(0, 1'b1, 32'h1000_0000, 4'd0, 2'b01);
      probe_exp(32'h1000_ABCD, 8'h01, 2'b01, 1'b0, "R2 inside 64K");
      probe_exp(32'h1000_FFFF, 8'h01, 2'b01, 1'b0, "R2 last byte 64K");
      probe_exp(32'h1001_0000, 8'h00, 2'b00, 1'b0, "R10 R2 past 64K");

      // R3 R5: 1 MB region with junk low base bits, width word
      cfg_write(1, 1'b1, 32'h2345_6789, 4'd4, 2'b10);
      probe_exp(32'h2340_0000, 8'h02, 2'b10, 1'b0, "R5 low base bits ignored");
      probe_exp(32'h234F_FFFF, 8'h02, 2'b10, 1'b0, "R3 top of 1M");
      probe_exp(32'h2350_0000, 8'h00, 2'b00, 1'b0, "R3 past 1M");

      // R4 R8: 2 GB region, width byte
      cfg_write(2, 1'b1, 32'h8000_1234, 4'd15, 2'b00);
      probe_exp(32'hFFFF_FFFF, 8'h04, 2'b00, 1'b0, "R4 R8 2G top byte width");
      probe_exp(32'h7FFF_FFFF, 8'h00, 2'b00, 1'b0, "R4 bit31 clear");

      // R7: overlap, lower index wins
      cfg_write(3, 1'b1, 32'h1000_0000, 4'd8, 2'b10);
      probe_exp(32'h1000_0010, 8'h01, 2'b01, 1'b0, "R7 region0 beats region3");
      probe_exp(32'h10FF_0000, 8'h08, 2'b10, 1'b0, "R7 only region3");

      // R6: disable region 0
      cfg_write(0, 1'b0, 32'h1000_0000, 4'd0, 2'b01);
      probe_exp(32'h1000_0010, 8'h08, 2'b10, 1'b0, "R6 disabled region0 skipped");

      // R9: reserved width shadows a higher-numbered match
      cfg_write(4, 1'b1, 32'h4000_0000, 4'd2, 2'b11);
      cfg_write(5, 1'b1, 32'h4000_0000, 4'd3, 2'b01);
      probe_exp(32'h4000_1234, 8'h00, 2'b00, 1'b1, "R9 reserved width error");
      probe_exp(32'h4004_0000, 8'h20, 2'b01, 1'b0, "R9 outside reserved, region5");

      // R11: inputs without strobe ignored
      @(negedge clk);
      cfg_idx = 3'd6; cfg_en = 1'b1; cfg_base = 32'h5000_0000;
      cfg_size = 4'd0; cfg_width = 2'b10;
      @(negedge clk);
      probe_exp(32'h5000_0000, 8'h00, 2'b00, 1'b0, "R11 no strobe no change");
      cfg_write(7, 1'b1, 32'h5000_0000, 4'd0, 2'b01);
      probe_exp(32'h5000_0000, 8'h80, 2'b01, 1'b0, "R11 region7 written, region6 untouched");
      probe_exp(32'h10FF_0000, 8'h08, 2'b10, 1'b0, "R11 region3 kept");

      // R3 sweep over all size codes on region 7
      for (int k = 0; k < 16; k++) begin
         logic [31:0] top;
         top = 32'h6000_0000 + ((32'd1 << (16 + k)) - 32'd1);
         cfg_write(7, 1'b1, 32'h6000_0000, 4'(k), 2'b10);
         probe(32'h6000_0000 | ((32'd1 << (16 + k)) - 32'd1), $sformatf("R3 sweep k=%0d inside", k));
         probe(top + 32'd1, $sformatf("R3 sweep k=%0d outside", k));
      end

      wait (q.size() == 0);
      #2;
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule